// File: doc/BRIEF.md
# Z80 Bus Cycle Classifier and Wait-State Inserter

This block sits beside the socket of a Z80-style host bus and watches its control lines from a fast system clock. It sorts every machine cycle into one of six kinds: opcode fetch, memory read, memory write, I/O read, I/O write or interrupt acknowledge. The kind is shown on a 3-bit output. The block also raises one-clock event pulses on an 8-bit vector when a cycle's command strobe asserts, when its data phase opens, at the host clock edge that opens T1, and when host reset, NMI or a bus grant occurs.

It can also stretch any cycle. The wait count presented at the T1 edge decides how many extra T-states the block holds the host wait line low, starting at the T2 rising edge. While a bus request is being honoured, the block signals that its control and data drivers must float. In that state it raises no T1 events and inserts no waits. All socket inputs are asynchronous to the system clock. Each one passes through a two-flop synchroniser before any edge is taken from it.

Top module: `busCycleMonitor`

## Requirements
- R1: `cycleType` reads 0 after system reset. A cycle with M1, MREQ and RD active reports 1 (fetch). MREQ with RD and without M1 reports 2 (memory read). MREQ with WR reports 3 (memory write). The code holds until the next cycle is classified.
- R2: IORQ with RD and without M1 reports 4 (I/O read). IORQ with WR reports 5 (I/O write).
- R3: M1 together with IORQ reports 6 (interrupt acknowledge). Such a cycle is never reported as 4 or 5, and it raises no data-phase event.
- R4: `eventVec[0]` (cycle start) pulses exactly once per cycle, when MREQ or IORQ becomes active. An MREQ that is active while RFSH is active (a refresh) raises no start or data event and leaves `cycleType` unchanged.
- R5: `eventVec[1]` (data phase) pulses once when RD or WR first becomes active in a cycle.
- R6: `eventVec[2]` (T1) pulses once per cycle, at the first host clock rising edge after the previous cycle's MREQ/IORQ have all gone inactive. It does not pulse at the later rising edges of that cycle, including those during refresh.
- R7: For a latched wait count N, `hostWaitN` is low at exactly N consecutive host clock falling edges, starting with the falling edge of T2. With N = 0 it stays high.
- R8: On a bus request, `busRelease` rises only once no MREQ, IORQ, M1 or RFSH is active and no wait is pending. It stays high while the request is held. `eventVec[6]` pulses once when it rises. While it is high, no T1 event occurs and `hostWaitN` stays high.
- R9: A falling edge of host reset pulses `eventVec[3]`. While host reset is active, `cycleType` is 0, `hostWaitN` is high and `busRelease` is low.
- R10: A falling edge of host NMI pulses `eventVec[4]`. Its release raises nothing.
- R11: Every event bit is a single-clock pulse. Bits 5 and 7 are always 0.
- R12: Each asynchronous input passes through two synchroniser flops and one event register. An NMI edge applied between system clock edges shows on `eventVec[4]` after the third system clock rising edge, and only for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low system reset |
| hostClk | input | 1 | Host bus clock as seen at the socket |
| hostMreqN | input | 1 | Host memory request, active low |
| hostIorqN | input | 1 | Host I/O request, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostM1N | input | 1 | Host machine-cycle-one marker, active low |
| hostRfshN | input | 1 | Host refresh marker, active low |
| hostResetN | input | 1 | Host reset line, active low |
| hostNmiN | input | 1 | Host non-maskable interrupt, active low |
| hostBusrqN | input | 1 | Host bus request, active low |
| waitCount | input | WAIT_W | Extra T-states for the cycle, latched at the T1 edge |
| hostWaitN | output | 1 | Wait line to the host, active low |
| busRelease | output | 1 | High while control strobes and data bus must float |
| cycleType | output | 3 | Kind of the last classified cycle |
| eventVec | output | 8 | One-clock event pulses, fixed bit positions |

## Verification
The assertions assume the host clock is slow next to the system clock, with each half period spanning at least six system clocks. They also assume that strobes change only together with a host clock edge, and that the strobes belonging to one step of a cycle change at the same instant, so they leave the synchronisers on the same clock. The bench keeps within this by building every cycle from host clock half periods of exactly six system clocks. It changes strobes only at those steps and drives every input just after a system clock falling edge. Cycle kinds and wait counts come from a seeded random source. Bus requests, host reset and refresh-only activity appear only in directed sequences placed between whole cycles.

// File: rtl/busMonPkg.sv
package busMonPkg;

  typedef enum logic [2:0] {
    CY_NONE   = 3'd0,
    CY_FETCH  = 3'd1,
    CY_MEMRD  = 3'd2,
    CY_MEMWR  = 3'd3,
    CY_IORD   = 3'd4,
    CY_IOWR   = 3'd5,
    CY_INTACK = 3'd6
  } cycleKind_e;

  // positions inside the event vector
  localparam int EV_START = 0;
  localparam int EV_DATA  = 1;
  localparam int EV_T1    = 2;
  localparam int EV_RESET = 3;
  localparam int EV_NMI   = 4;
  localparam int EV_GRANT = 6;
  localparam int EV_WIDTH = 8;

  // positions inside the synchronised, active-high pin vector
  localparam int PIN_CLK   = 0;
  localparam int PIN_MREQ  = 1;
  localparam int PIN_IORQ  = 2;
  localparam int PIN_RD    = 3;
  localparam int PIN_WR    = 4;
  localparam int PIN_M1    = 5;
  localparam int PIN_RFSH  = 6;
  localparam int PIN_RESET = 7;
  localparam int PIN_NMI   = 8;
  localparam int PIN_BUSRQ = 9;
  localparam int PIN_COUNT = 10;

  typedef struct packed {
    logic       startHit;
    logic       dataHit;
    logic       t1Hit;
    logic       rstHit;
    logic       nmiHit;
    logic       grantHit;
    logic       typeLoad;
    cycleKind_e typeCode;
    logic       typeClear;
    logic       pendLoad;
    logic       waitLoad;
    logic       waitDec;
  } monStrobe_t;

endpackage

// File: rtl/inputSync.sv
module inputSync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage[s] <= '0;
      end else if (s == 0) begin
        stage[s] <= asyncIn;
      end else begin
        stage[s] <= stage[(s > 0) ? s - 1 : 0];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/busMonCtrl.sv
module busMonCtrl
  import busMonPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinAct,
  input  logic                 pendZero,
  input  logic                 cntLast,
  output monStrobe_t           strobe,
  output logic                 waitLow,
  output logic                 granted
);

  logic clkNow, mreq, iorq, rd, wr, m1, rfsh, hostRst, nmi, busrq;
  assign clkNow  = pinAct[PIN_CLK];
  assign mreq    = pinAct[PIN_MREQ];
  assign iorq    = pinAct[PIN_IORQ];
  assign rd      = pinAct[PIN_RD];
  assign wr      = pinAct[PIN_WR];
  assign m1      = pinAct[PIN_M1];
  assign rfsh    = pinAct[PIN_RFSH];
  assign hostRst = pinAct[PIN_RESET];
  assign nmi     = pinAct[PIN_NMI];
  assign busrq   = pinAct[PIN_BUSRQ];

  logic clkPrev, rstPrev, nmiPrev, busyPrev, cmdPrev, xferPrev;
  logic resolved, armed, t2Next;

  logic busy, cmdActive, xfer, clkRise, busyEnd, t1Fire, grantCond;
  cycleKind_e decoded;

  assign busy      = mreq | iorq;
  assign cmdActive = (mreq & ~rfsh) | iorq;
  assign xfer      = rd | wr;
  assign clkRise   = clkNow & ~clkPrev;
  assign busyEnd   = busyPrev & ~busy;
  assign t1Fire    = clkRise & armed & ~granted & ~hostRst;
  assign grantCond = busrq & ~granted & ~busy & ~m1 & ~rfsh
                   & ~waitLow & ~t2Next & ~hostRst;

  // acknowledge is tested first so it can never fall through to an I/O kind
  always_comb begin
    if (m1 & iorq)               decoded = CY_INTACK;
    else if (m1 & mreq & rd)     decoded = CY_FETCH;
    else if (mreq & ~rfsh & rd)  decoded = CY_MEMRD;
    else if (mreq & ~rfsh & wr)  decoded = CY_MEMWR;
    else if (iorq & rd)          decoded = CY_IORD;
    else if (iorq & wr)          decoded = CY_IOWR;
    else                         decoded = CY_NONE;
  end

  always_comb begin
    strobe           = '0;
    strobe.startHit  = cmdActive & ~cmdPrev & ~hostRst;
    strobe.dataHit   = xfer & ~xferPrev & ~hostRst;
    strobe.t1Hit     = t1Fire;
    strobe.rstHit    = hostRst & ~rstPrev;
    strobe.nmiHit    = nmi & ~nmiPrev;
    strobe.grantHit  = grantCond;
    strobe.typeLoad  = cmdActive & ~resolved & (decoded != CY_NONE) & ~hostRst;
    strobe.typeCode  = decoded;
    strobe.typeClear = hostRst;
    strobe.pendLoad  = t1Fire;
    strobe.waitLoad  = clkRise & ~waitLow & t2Next & ~pendZero & ~hostRst;
    strobe.waitDec   = clkRise & waitLow & ~cntLast & ~hostRst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      rstPrev  <= 1'b0;
      nmiPrev  <= 1'b0;
      busyPrev <= 1'b0;
      cmdPrev  <= 1'b0;
      xferPrev <= 1'b0;
      resolved <= 1'b0;
      armed    <= 1'b1;
      t2Next   <= 1'b0;
      waitLow  <= 1'b0;
      granted  <= 1'b0;
    end else begin
      clkPrev  <= clkNow;
      rstPrev  <= hostRst;
      nmiPrev  <= nmi;
      busyPrev <= busy;
      cmdPrev  <= cmdActive;
      xferPrev <= xfer;
      if (hostRst) begin
        resolved <= 1'b0;
        armed    <= 1'b1;
        t2Next   <= 1'b0;
        waitLow  <= 1'b0;
        granted  <= 1'b0;
      end else begin
        if (!cmdActive)                 resolved <= 1'b0;
        else if (decoded != CY_NONE)    resolved <= 1'b1;

        if (t1Fire || busy)             armed <= 1'b0;
        else if (busyEnd)               armed <= 1'b1;

        if (clkRise) begin
          if (waitLow) begin
            if (cntLast) waitLow <= 1'b0;
          end else if (t2Next) begin
            t2Next <= 1'b0;
            if (!pendZero) waitLow <= 1'b1;
          end
          if (t1Fire) t2Next <= 1'b1;
        end

        if (granted && !busrq)          granted <= 1'b0;
        else if (grantCond)             granted <= 1'b1;
      end
    end
  end

  // R7: the wait line may only drop in response to a host clock rising edge
  assert_wait_on_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitLow) |-> $past(clkRise));

  // R8: a granted bus never carries an inserted wait
  assert_no_wait_granted_R8: assert property (@(posedge clk) disable iff (!rstN)
    granted |-> !waitLow);

  // R3: an acknowledge pattern is loaded as acknowledge, never as I/O
  assert_ack_not_io_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.typeLoad && m1 && iorq) |-> (strobe.typeCode == CY_INTACK));

  // R9: host reset quiets the wait and grant state on the next clock
  assert_reset_quiets_R9: assert property (@(posedge clk) disable iff (!rstN)
    hostRst |=> (!waitLow && !granted));

endmodule

// File: rtl/busMonData.sv
module busMonData
  import busMonPkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  monStrobe_t          strobe,
  input  logic [WAIT_W-1:0]   waitCount,
  output logic [EV_WIDTH-1:0] eventVec,
  output cycleKind_e          cycleType,
  output logic                pendZero,
  output logic                cntLast
);

  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  logic [WAIT_W-1:0]   waitPend;
  logic [WAIT_W-1:0]   waitCnt;
  logic [EV_WIDTH-1:0] eventNext;

  always_comb begin
    eventNext           = '0;
    eventNext[EV_START] = strobe.startHit;
    eventNext[EV_DATA]  = strobe.dataHit;
    eventNext[EV_T1]    = strobe.t1Hit;
    eventNext[EV_RESET] = strobe.rstHit;
    eventNext[EV_NMI]   = strobe.nmiHit;
    eventNext[EV_GRANT] = strobe.grantHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eventVec  <= '0;
      cycleType <= CY_NONE;
      waitPend  <= '0;
      waitCnt   <= '0;
    end else begin
      eventVec <= eventNext;
      if (strobe.typeClear)     cycleType <= CY_NONE;
      else if (strobe.typeLoad) cycleType <= strobe.typeCode;
      if (strobe.pendLoad)      waitPend  <= waitCount;
      if (strobe.waitLoad)      waitCnt   <= waitPend;
      else if (strobe.waitDec)  waitCnt   <= waitCnt - ONE;
    end
  end

  assign pendZero = (waitPend == '0);
  assign cntLast  = (waitCnt == ONE);

  // R7: the control never counts below zero
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.waitDec |-> (waitCnt != '0));

  // R11: no event bit stays high for two clocks
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    (eventVec & $past(eventVec)) == '0);

endmodule

// File: rtl/busCycleMonitor.sv
module busCycleMonitor
  import busMonPkg::*;
#(
  parameter int WAIT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostClk,
  input  logic              hostMreqN,
  input  logic              hostIorqN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic              hostM1N,
  input  logic              hostRfshN,
  input  logic              hostResetN,
  input  logic              hostNmiN,
  input  logic              hostBusrqN,
  input  logic [WAIT_W-1:0] waitCount,
  output logic              hostWaitN,
  output logic              busRelease,
  output logic [2:0]        cycleType,
  output logic [7:0]        eventVec
);

  logic [PIN_COUNT-1:0] pinRaw, pinAct;
  monStrobe_t           strobe;
  logic                 pendZero, cntLast, waitLow, granted;
  cycleKind_e           kind;

  always_comb begin
    pinRaw            = '0;
    pinRaw[PIN_CLK]   = hostClk;
    pinRaw[PIN_MREQ]  = ~hostMreqN;
    pinRaw[PIN_IORQ]  = ~hostIorqN;
    pinRaw[PIN_RD]    = ~hostRdN;
    pinRaw[PIN_WR]    = ~hostWrN;
    pinRaw[PIN_M1]    = ~hostM1N;
    pinRaw[PIN_RFSH]  = ~hostRfshN;
    pinRaw[PIN_RESET] = ~hostResetN;
    pinRaw[PIN_NMI]   = ~hostNmiN;
    pinRaw[PIN_BUSRQ] = ~hostBusrqN;
  end

  inputSync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(pinRaw), .syncOut(pinAct)
  );

  busMonCtrl uCtrl (
    .clk(clk), .rstN(rstN), .pinAct(pinAct), .pendZero(pendZero),
    .cntLast(cntLast), .strobe(strobe), .waitLow(waitLow), .granted(granted)
  );

  busMonData #(.WAIT_W(WAIT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .waitCount(waitCount),
    .eventVec(eventVec), .cycleType(kind), .pendZero(pendZero), .cntLast(cntLast)
  );

  assign cycleType  = kind;
  assign hostWaitN  = ~waitLow;
  assign busRelease = granted;

endmodule

// File: tb/busCycleMonitor_test.sv
`timescale 1ns/100ps
module busCycleMonitor_test;

  localparam int WAIT_W = 4;
  localparam int HALF   = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostClk = 1'b0;
  logic hostMreqN = 1'b1, hostIorqN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1;
  logic hostM1N = 1'b1, hostRfshN = 1'b1, hostResetN = 1'b1, hostNmiN = 1'b1;
  logic hostBusrqN = 1'b1;
  logic [WAIT_W-1:0] waitCount = '0;
  logic hostWaitN, busRelease;
  logic [2:0] cycleType;
  logic [7:0] eventVec;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int evCnt [8];
  int evBase [8];
  int dblCnt = 0;
  int oddCnt = 0;
  int waitLowCnt = 0;
  logic [7:0] prevEv = '0;

  always #2 clk = ~clk;

  busCycleMonitor #(.WAIT_W(WAIT_W)) uut (
    .clk(clk), .rstN(rstN), .hostClk(hostClk), .hostMreqN(hostMreqN),
    .hostIorqN(hostIorqN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostM1N(hostM1N), .hostRfshN(hostRfshN), .hostResetN(hostResetN),
    .hostNmiN(hostNmiN), .hostBusrqN(hostBusrqN), .waitCount(waitCount),
    .hostWaitN(hostWaitN), .busRelease(busRelease), .cycleType(cycleType),
    .eventVec(eventVec)
  );

  initial for (int b = 0; b < 8; b++) begin evCnt[b] = 0; evBase[b] = 0; end

  always @(negedge clk) begin
    if (rstN) begin
      for (int b = 0; b < 8; b++) if (eventVec[b]) evCnt[b]++;
      if ((eventVec & prevEv) != 0) dblCnt++;
      if (eventVec[5] || eventVec[7]) oddCnt++;
      if (!hostWaitN) waitLowCnt++;
      prevEv = eventVec;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic snap();
    for (int b = 0; b < 8; b++) evBase[b] = evCnt[b];
  endtask

  function automatic int delta(input int b);
    return evCnt[b] - evBase[b];
  endfunction

  // kind numbers: 1 fetch, 2 mem read, 3 mem write, 4 io read, 5 io write, 6 ack
  function automatic int expType(input int kind);
    case (kind)
      1: return 1;  // R1 fetch
      2: return 2;  // R1 memory read
      3: return 3;  // R1 memory write
      4: return 4;  // R2 io read
      5: return 5;  // R2 io write
      6: return 6;  // R3 acknowledge
      default: return 0;
    endcase
  endfunction

  function automatic int expData(input int kind);
    return (kind == 6) ? 0 : 1;
  endfunction

  task automatic runCycle(input int kind, input int nWait, output int seen);
    bit first;
    bit stretch;
    logic sampled;
    seen = 0;
    waitCount = nWait[WAIT_W-1:0];
    hostClk = 1'b1;                                   // T1 rise
    if (kind == 1 || kind == 6) hostM1N = 1'b0;
    tick(HALF);
    hostClk = 1'b0;                                   // T1 fall
    if (kind == 1 || kind == 2) begin hostMreqN = 1'b0; hostRdN = 1'b0; end
    if (kind == 3) hostMreqN = 1'b0;
    tick(HALF);
    hostClk = 1'b1;                                   // T2 rise
    if (kind == 4) begin hostIorqN = 1'b0; hostRdN = 1'b0; end
    if (kind == 5) begin hostIorqN = 1'b0; hostWrN = 1'b0; end
    tick(HALF);
    first = 1'b1;
    stretch = 1'b1;
    while (stretch) begin
      sampled = hostWaitN;
      hostClk = 1'b0;
      if (first) begin
        if (kind == 3) hostWrN = 1'b0;
        if (kind == 6) hostIorqN = 1'b0;
        first = 1'b0;
      end
      tick(HALF);
      if (sampled || seen > 40) stretch = 1'b0;
      else begin
        seen++;
        hostClk = 1'b1;
        tick(HALF);
      end
    end
    hostClk = 1'b1;                                   // T3 rise
    if (kind == 1) begin
      hostMreqN = 1'b1; hostRdN = 1'b1; hostM1N = 1'b1; hostRfshN = 1'b0;
    end
    tick(HALF);
    hostClk = 1'b0;                                   // T3 fall
    if (kind == 1) hostMreqN = 1'b0;
    else begin
      hostMreqN = 1'b1; hostIorqN = 1'b1; hostRdN = 1'b1; hostWrN = 1'b1;
      hostM1N = 1'b1;
    end
    tick(HALF);
    if (kind == 1) begin
      hostClk = 1'b1; tick(HALF);                     // T4
      hostClk = 1'b0; hostMreqN = 1'b1; tick(HALF);
      hostRfshN = 1'b1;
    end
    tick(10);
  endtask

  task automatic cycleAndCheck(input int kind, input int nWait);
    int seen;
    snap();
    runCycle(kind, nWait, seen);
    check(cycleType == expType(kind), (kind <= 3) ? "R1 type" : (kind == 6 ? "R3 type" : "R2 type"),
          cycleType, expType(kind));
    check(delta(0) == 1, "R4 start pulse", delta(0), 1);
    check(delta(1) == expData(kind), "R5 data pulse", delta(1), expData(kind));
    check(delta(2) == 1, "R6 t1 pulse", delta(2), 1);
    check(seen == nWait, "R7 wait states", seen, nWait);
  endtask

  initial begin
    int held;
    void'($urandom(32'h5EED_0042));
    tick(5);
    rstN = 1'b1;
    tick(2);
    // reset state
    check(cycleType == 0, "R1 reset type", cycleType, 0);
    check(hostWaitN == 1'b1, "R9 reset wait", hostWaitN, 1);
    check(busRelease == 1'b0, "R8 reset release", busRelease, 0);
    check(eventVec == 8'h00, "R11 reset events", eventVec, 0);

    // directed: zero and maximum wait counts, every kind once
    cycleAndCheck(2, 0);
    cycleAndCheck(3, 15);
    for (int k = 1; k <= 6; k++) cycleAndCheck(k, 1);

    // R4: refresh-only activity
    snap();
    hostRfshN = 1'b0; tick(HALF);
    hostMreqN = 1'b0; tick(HALF);
    hostMreqN = 1'b1; tick(HALF);
    hostRfshN = 1'b1; tick(10);
    check(delta(0) == 0, "R4 refresh start", delta(0), 0);
    check(delta(1) == 0, "R4 refresh data", delta(1), 0);
    check(cycleType == 6, "R4 refresh keeps type", cycleType, 6);

    // R10/R12: NMI latency and release
    snap();
    hostNmiN = 1'b0;
    tick(2); check(eventVec[4] == 1'b0, "R12 nmi early", eventVec[4], 0);
    tick(1); check(eventVec[4] == 1'b1, "R12 nmi third clock", eventVec[4], 1);
    tick(1); check(eventVec[4] == 1'b0, "R12 nmi one clock", eventVec[4], 0);
    hostNmiN = 1'b1; tick(10);
    check(delta(4) == 1, "R10 nmi count", delta(4), 1);

    // random cycles
    for (int i = 0; i < 40; i++) begin
      int kind;
      int nw;
      kind = 1 + int'($urandom % 6);
      nw = int'($urandom % 6);
      cycleAndCheck(kind, nw);
    end

    // R8: bus request during a memory read
    snap();
    waitCount = '0;
    hostClk = 1'b1; tick(HALF);
    hostClk = 1'b0; hostMreqN = 1'b0; hostRdN = 1'b0; tick(HALF);
    hostClk = 1'b1; hostBusrqN = 1'b0; tick(HALF);
    check(busRelease == 1'b0, "R8 no release mid cycle", busRelease, 0);
    hostClk = 1'b0; tick(HALF);
    hostClk = 1'b1; tick(HALF);
    check(busRelease == 1'b0, "R8 no release T3", busRelease, 0);
    hostClk = 1'b0; hostMreqN = 1'b1; hostRdN = 1'b1; tick(10);
    check(busRelease == 1'b1, "R8 release after cycle", busRelease, 1);
    check(delta(6) == 1, "R8 grant event", delta(6), 1);
    snap();
    held = waitLowCnt;
    waitCount = 4'd3;
    for (int j = 0; j < 3; j++) begin
      hostClk = 1'b1; tick(HALF);
      hostClk = 1'b0; tick(HALF);
    end
    check(delta(2) == 0, "R8 no t1 while granted", delta(2), 0);
    check(waitLowCnt == held, "R8 no wait while granted", waitLowCnt - held, 0);
    check(busRelease == 1'b1, "R8 release held", busRelease, 1);

    // R9: host reset while granted
    hostResetN = 1'b0; tick(8);
    check(delta(3) == 1, "R9 reset event", delta(3), 1);
    check(busRelease == 1'b0, "R9 release dropped", busRelease, 0);
    check(cycleType == 0, "R9 type cleared", cycleType, 0);
    check(hostWaitN == 1'b1, "R9 wait released", hostWaitN, 1);
    hostBusrqN = 1'b1; tick(2);
    hostResetN = 1'b1; tick(8);
    check(delta(3) == 1, "R9 no event on release", delta(3), 1);
    cycleAndCheck(2, 2);

    // R11: pulse shape over the whole run
    check(dblCnt == 0, "R11 single pulses", dblCnt, 0);
    check(oddCnt == 0, "R11 unused bits", oddCnt, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule